// File: doc/BRIEF.md
# Pseudorandom RAM Fill Engine

This block loads a 255-entry, 8-bit data RAM with a pseudorandom byte sequence at full clock rate. A processor starts it by writing the control register with the start bit set. The engine then drives the RAM write port directly and writes one byte per cycle to addresses 0x00 through 0xFE. When the last byte has been written, it raises a done flag in its status register.

The sequence comes from a mod-256 linear congruential generator: next = (0x11 * current + 0x9D) mod 256, with unsigned multiplication. The seed 0xD7 goes to address 0x00, and each following address holds the next term.

While the engine is filling, it owns the RAM write port. Any processor write that arrives during that time is dropped. When the engine is idle, processor writes reach the RAM unchanged, one cycle later.

Top module: `lcg_fill_engine`

## Requirements
- R1: Reset is synchronous and active high. While it is held, and in the first cycle after it is released, `ram_we` is 0 and `status_q` is 0x00.
- R2: In every fill, the first engine write goes to address 0x00 with data 0xD7.
- R3: Each later engine write holds (0x11 * previous + 0x9D) mod 256, where previous is the byte written one cycle earlier.
- R4: A fill makes exactly 255 writes, one per cycle with no gaps, at addresses 0x00, 0x01, … 0xFE. In the cycle after the write to 0xFE, `ram_we` follows the processor port again.
- R5: Status bit 0 (done) is 0 during a fill. It reads 1 from the cycle in which the write to 0xFE appears on the RAM port, and it stays 1 until the next control write.
- R6: While the engine is idle, any control write clears the done bit one cycle later, whatever value is written.
- R7: An idle control write with bit 0 set starts a fill. The write to 0x00 appears two cycles after the cycle in which `ctrl_wr` is sampled. An idle control write with bit 0 clear starts nothing.
- R8: While the engine is idle, a processor RAM write appears on `ram_we`/`ram_addr`/`ram_wdata` one cycle later. Processor writes sampled while a fill is running are dropped.
- R9: A control write during a fill is ignored. The fill runs on unchanged and does not restart.
- R10: Status bits 7 to 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; bit 0 = start |
| status_q | output | 8 | Status register; bit 0 = done |
| cpu_ram_we | input | 1 | Processor RAM write enable |
| cpu_ram_addr | input | 8 | Processor RAM write address |
| cpu_ram_wdata | input | 8 | Processor RAM write data |
| ram_we | output | 1 | Registered RAM write enable |
| ram_addr | output | 8 | Registered RAM write address |
| ram_wdata | output | 8 | Registered RAM write data |

## Verification
A start write sampled at edge T puts address k on the RAM port after edge T+k+1. The done bit appears after the same edge that carries address 0xFE. A processor write or a clearing control write shows its effect after the very next edge.

The bench changes inputs on the falling edge and samples on the following falling edge. Every expected value is therefore read half a cycle after the rising edge that produced it, and each loop step accounts for exactly one edge. The checker properties encode the same offsets with `|=>` and same-cycle implications.

// File: rtl/lcg_fill_pkg.sv
package lcg_fill_pkg;

  localparam int unsigned FILL_W_DEF     = 8;
  localparam int unsigned FILL_DEPTH_DEF = 255;
  localparam logic [7:0]  LCG_MULT_DEF   = 8'h11;
  localparam logic [7:0]  LCG_INCR_DEF   = 8'h9D;
  localparam logic [7:0]  LCG_SEED_DEF   = 8'hD7;

  // bit positions the processor decodes
  localparam int unsigned CTRL_START_BIT = 0;
  localparam int unsigned STAT_DONE_BIT  = 0;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/lcg_core.sv
module lcg_core #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] MULT = 8'h11,
  parameter logic [W-1:0] INCR = 8'h9D,
  parameter logic [W-1:0] SEED = 8'hD7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] val_q
);

  logic [W-1:0] nxt;

  // shift-add over multiplier bits; W-bit sums wrap mod 2^W
  always_comb begin
    nxt = INCR;
    for (int i = 0; i < int'(W); i++) begin
      if (MULT[i]) nxt = nxt + (val_q << i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       val_q <= SEED;
    else if (load) val_q <= SEED;
    else if (step) val_q <= nxt;
  end

endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer
  import lcg_fill_pkg::*;
#(
  parameter int unsigned DEPTH  = 255,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              start_bit,
  output logic              busy,
  output logic              done_q,
  output logic              load_seed,
  output logic              step,
  output logic [ADDR_W-1:0] idx_q
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

  seq_state_t state_q;

  assign busy      = (state_q == SEQ_RUN);
  assign load_seed = ctrl_wr && start_bit && !busy;
  assign step      = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (ctrl_wr) begin
            done_q <= 1'b0;
            if (start_bit) begin
              state_q <= SEQ_RUN;
              idx_q   <= '0;
            end
          end
        end
        SEQ_RUN: begin
          if (idx_q == LAST_IDX) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + ADDR_W'(1);
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wport_mux.sv
module wport_mux #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eng_sel,
  input  logic [ADDR_W-1:0] eng_addr,
  input  logic [W-1:0]      eng_data,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [W-1:0]      cpu_data,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [W-1:0]      data_q,
  output logic              src_eng_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q      <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      src_eng_q <= 1'b0;
    end else if (eng_sel) begin
      we_q      <= 1'b1;
      addr_q    <= eng_addr;
      data_q    <= eng_data;
      src_eng_q <= 1'b1;
    end else begin
      we_q      <= cpu_we;
      addr_q    <= cpu_addr;
      data_q    <= cpu_data;
      src_eng_q <= 1'b0;
    end
  end

endmodule

// File: rtl/lcg_fill_engine.sv
module lcg_fill_engine
  import lcg_fill_pkg::*;
#(
  parameter int unsigned     DATA_W = FILL_W_DEF,
  parameter int unsigned     DEPTH  = FILL_DEPTH_DEF,
  parameter logic [DATA_W-1:0] MULT = LCG_MULT_DEF,
  parameter logic [DATA_W-1:0] INCR = LCG_INCR_DEF,
  parameter logic [DATA_W-1:0] SEED = LCG_SEED_DEF,
  localparam int unsigned    ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic [DATA_W-1:0] status_q,
  input  logic              cpu_ram_we,
  input  logic [ADDR_W-1:0] cpu_ram_addr,
  input  logic [DATA_W-1:0] cpu_ram_wdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);

  logic              busy;
  logic              done_q;
  logic              load_seed;
  logic              step;
  logic [ADDR_W-1:0] idx_q;
  logic [DATA_W-1:0] val_q;
  logic              src_eng;
  logic              ctrl_unused_bits;

  assign ctrl_unused_bits = ^ctrl_wdata;

  fill_sequencer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .start_bit (ctrl_wdata[CTRL_START_BIT]),
    .busy      (busy),
    .done_q    (done_q),
    .load_seed (load_seed),
    .step      (step),
    .idx_q     (idx_q)
  );

  lcg_core #(.W(DATA_W), .MULT(MULT), .INCR(INCR), .SEED(SEED)) u_gen (
    .clk   (clk),
    .rst   (rst),
    .load  (load_seed),
    .step  (step),
    .val_q (val_q)
  );

  wport_mux #(.ADDR_W(ADDR_W), .W(DATA_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .eng_sel   (busy),
    .eng_addr  (idx_q),
    .eng_data  (val_q),
    .cpu_we    (cpu_ram_we),
    .cpu_addr  (cpu_ram_addr),
    .cpu_data  (cpu_ram_wdata),
    .we_q      (ram_we),
    .addr_q    (ram_addr),
    .data_q    (ram_wdata),
    .src_eng_q (src_eng)
  );

  always_comb begin
    status_q                = '0;
    status_q[STAT_DONE_BIT] = done_q;
  end

endmodule

// File: rtl/lcg_fill_checker.sv
module lcg_fill_checker (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_wdata,
  input logic       busy,
  input logic       src_eng,
  input logic       cpu_ram_we,
  input logic       ram_we,
  input logic [7:0] ram_addr,
  input logic [7:0] ram_wdata,
  input logic [7:0] status_q
);

  function automatic logic [7:0] nxt8(input logic [7:0] v);
    logic [15:0] p;
    p = 16'(v) * 16'h0011 + 16'h009D;
    return p[7:0];
  endfunction

  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_q[7:1] == 7'd0); // R10
  AST_SEED_FIRST: assert property (@(posedge clk) disable iff (rst)
    (src_eng && ram_addr == 8'h00) |-> ram_wdata == 8'hD7); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (src_eng && ram_addr != 8'hFE) |=> (src_eng && ram_we && ram_addr == $past(ram_addr) + 8'd1)); // R4
  AST_VALUE_STEP: assert property (@(posedge clk) disable iff (rst)
    (src_eng && ram_addr != 8'hFE) |=> ram_wdata == nxt8($past(ram_wdata))); // R3
  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (src_eng && ram_addr == 8'hFE) |-> status_q[0]); // R5
  AST_DONE_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !status_q[0]); // R5
  AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !busy) |=> !status_q[0]); // R6
  AST_START_GOES: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_wdata[0] && !busy) |=> busy); // R7
  AST_CPU_PASS: assert property (@(posedge clk) disable iff (rst)
    (!busy && cpu_ram_we) |=> (ram_we && !src_eng)); // R8

endmodule

bind lcg_fill_engine lcg_fill_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .busy       (busy),
  .src_eng    (src_eng),
  .cpu_ram_we (cpu_ram_we),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .ram_wdata  (ram_wdata),
  .status_q   (status_q)
);

// File: tb/sim_lcg_fill_engine.sv
`timescale 1ns/1ps
module sim_lcg_fill_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] status_q;
  logic       cpu_ram_we = 1'b0;
  logic [7:0] cpu_ram_addr = 8'h00;
  logic [7:0] cpu_ram_wdata = 8'h00;
  logic       ram_we;
  logic [7:0] ram_addr;
  logic [7:0] ram_wdata;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lcg_fill_engine u0 (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .status_q(status_q), .cpu_ram_we(cpu_ram_we), .cpu_ram_addr(cpu_ram_addr),
    .cpu_ram_wdata(cpu_ram_wdata), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata)
  );

  function automatic logic [7:0] lcg_model(input logic [7:0] v);
    logic [15:0] p;
    p = 16'(v) * 16'd17 + 16'd157;
    return p[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // start is assumed driven at a negedge just before; runs one full fill
  task automatic run_fill(input bit disturb);
    logic [7:0] expv;
    expv = 8'hD7;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk("R7 no write yet", 32'(ram_we), 32'(cpu_ram_we));
    cpu_ram_we = 1'b0;
    for (int k = 0; k < 255; k++) begin
      @(negedge clk);
      chk("R4 we", 32'(ram_we), 1);
      chk("R4 addr", 32'(ram_addr), 32'(k));
      chk(k == 0 ? "R2 seed" : "R3 value", 32'(ram_wdata), 32'(expv));
      chk("R5 done", 32'(status_q), (k == 254) ? 1 : 0);
      expv = lcg_model(expv);
      if (disturb && k < 254) begin
        cpu_ram_we    = 1'($urandom % 2);
        cpu_ram_addr  = 8'($urandom);
        cpu_ram_wdata = 8'($urandom);
        ctrl_wr       = (k == 100) || (k == 200);   // R9 ignored mid-fill
        ctrl_wdata    = (k == 100) ? 8'h01 : 8'h00;
      end else begin
        cpu_ram_we = 1'b0;
        ctrl_wr    = 1'b0;
      end
    end
    @(negedge clk);
    chk("R4 stop", 32'(ram_we), 0);
    chk("R5 hold", 32'(status_q), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_init;
    logic [7:0] a, d;
    seed_init = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    chk("R1 we in reset", 32'(ram_we), 0);
    chk("R1 status in reset", 32'(status_q), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 we after reset", 32'(ram_we), 0);
    chk("R1 status after reset", 32'(status_q), 0);

    // R8 idle pass-through, random patterns
    for (int i = 0; i < 8; i++) begin
      a = 8'($urandom); d = 8'($urandom);
      cpu_ram_we = 1'($urandom % 2); cpu_ram_addr = a; cpu_ram_wdata = d;
      @(negedge clk);
      chk("R8 pass we", 32'(ram_we), 32'(cpu_ram_we));
      if (cpu_ram_we) begin
        chk("R8 pass addr", 32'(ram_addr), 32'(a));
        chk("R8 pass data", 32'(ram_wdata), 32'(d));
      end
    end
    cpu_ram_we = 1'b0;

    // R7 start with bit 0 clear does nothing
    ctrl_wr = 1'b1; ctrl_wdata = 8'hFE;
    @(negedge clk);
    ctrl_wr = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R7 no start", 32'(ram_we), 0);
    end

    // first fill, disturbed by processor writes and control writes (R8, R9)
    ctrl_wr = 1'b1; ctrl_wdata = 8'h01;
    run_fill(1'b1);
    repeat (4) begin
      @(negedge clk);
      chk("R5 stays", 32'(status_q), 1);
      chk("R10 status", 32'(status_q[7:1]), 0);
    end

    // R6 clear without start
    ctrl_wr = 1'b1; ctrl_wdata = 8'h00;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk("R6 cleared", 32'(status_q), 0);
    @(negedge clk);
    chk("R6 no fill", 32'(ram_we), 0);

    // second fill, start word with all bits set, processor write alongside
    ctrl_wr = 1'b1; ctrl_wdata = 8'hFF;
    cpu_ram_we = 1'b1; cpu_ram_addr = 8'h42; cpu_ram_wdata = 8'h99;
    run_fill(1'b0);

    // restart straight from done: clears done and refills
    ctrl_wr = 1'b1; ctrl_wdata = 8'h01;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk("R6 restart clears", 32'(status_q), 0);
    @(negedge clk);
    chk("R2 restart addr", 32'(ram_addr), 0);
    chk("R2 restart seed", 32'(ram_wdata), 32'h0D7);
    repeat (260) @(negedge clk);
    chk("R5 restart done", 32'(status_q), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule